// File: doc/BRIEF.md
# Subset POWER Instruction Decoder

This block turns one 32-bit instruction word into the control fields that an execution pipeline needs. It covers a small subset of the POWER instruction set: register-register and immediate ALU operations, word/halfword/byte loads and stores (displacement, update and indexed forms), register compare, 32-bit rotate-and-mask, and the unconditional relative or absolute branch. The decoder is purely combinational. Every output follows the input word within the same cycle, and no clock or reset is involved.

The outputs are a compact operation code, a select and an enable for one write port and three read ports, a 32-bit immediate, the record, link and absolute-address flags, the update flag, the access length, the compare target field, and the rotate shift and mask bounds. Bit numbering follows big-endian convention: bit 0 is the most significant bit of `insn_i`. The fields are therefore primary opcode `insn_i[31:26]`, first register field `[25:21]`, second `[20:16]`, third `[15:11]`, extended opcode `[10:1]` and record bit `[0]`. Any word outside the subset raises `illegal_o` and produces a fully quiet output.

Top module: `power_subset_decoder`

## Requirements
- R1: `op_o` encodes the operation as follows: 0 none/illegal, 1 add (add, addi, addis), 2 and (and, andi.), 3 or (or, ori), 4 load, 5 store, 6 compare, 7 branch, 8 rotate. Primary opcodes: 14 addi, 15 addis, 24 ori, 28 andi., 32 lwz, 33 lwzu, 34 lbz, 40 lhz, 36 stw, 37 stwu, 38 stb, 44 sth, 18 b, 20 rlwimi, 21 rlwinm, 23 rlwnm. Under primary 31, the 10-bit extended opcode `insn_i[10:1]` selects 266 add, 28 and, 444 or, 0 cmp, 23 lwzx and 151 stwx.
- R2: For add, addi, addis and every load, field `[25:21]` is the write-port register and field `[20:16]` is on read port 1. For add and lwzx, field `[15:11]` is on read port 2.
- R3: For every store, field `[25:21]` is on read port 3 as the data source, and field `[20:16]` is on read port 1. Stores never enable the write port. stwx also puts `[15:11]` on read port 2.
- R4: For and, or, andi., ori and all rotates, field `[20:16]` is the write register and field `[25:21]` is on read port 3. The register forms (and, or) put `[15:11]` on read port 2.
- R5: `imm_o` equals the 16-bit field `[15:0]` zero-extended for addi, ori, andi. and the displacement loads and stores. For addis it equals that field shifted left by 16. It is 0 for all other instructions.
- R6: `upd_o` is 1 only for lwzu and stwu.
- R7: `len_o` is 4 for word, 2 for halfword and 1 for byte accesses, and 0 for every non-memory instruction.
- R8: `rc_o` equals `insn_i[0]` for add, and, or and the rotates. It is always 1 for andi. and 0 for every other instruction.
- R9: For a branch, `imm_o` is the 24-bit field `[25:2]` times 4, sign-extended from 26 bits. `aa_o` equals `insn_i[1]` and `lk_o` equals `insn_i[0]`. Both flags are 0 for non-branches, and a branch enables no register port.
- R10: For cmp, field `[20:16]` is on read port 1 and `[15:11]` on read port 2, no write is enabled, and `crf_o` equals `insn_i[25:23]`. `crf_o` is 0 for every other instruction.
- R11: For rotates, `mb_o` equals `[10:6]` and `me_o` equals `[5:1]`. For rlwinm and rlwimi, `sh_o` equals `[15:11]`. For rlwnm, `sh_o` is 0 and `[15:11]` is on read port 2. All three fields are 0 for non-rotates.
- R12: An unlisted primary opcode, or an unlisted extended opcode under 31, sets `illegal_o` and forces `op_o` to 0, all enables to 0, and every other output to 0.
- R13: A port that is not enabled shows select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word, big-endian bit numbering |
| illegal_o | output | 1 | Word is outside the supported subset |
| op_o | output | 4 | Operation code |
| wr_en_o | output | 1 | Write port in use |
| wr_sel_o | output | 5 | Write register |
| rd1_en_o | output | 1 | Read port 1 in use |
| rd1_sel_o | output | 5 | Read port 1 register |
| rd2_en_o | output | 1 | Read port 2 in use |
| rd2_sel_o | output | 5 | Read port 2 register |
| rd3_en_o | output | 1 | Read port 3 in use |
| rd3_sel_o | output | 5 | Read port 3 register |
| imm_o | output | 32 | Immediate value |
| rc_o | output | 1 | Record result to condition field 0 |
| lk_o | output | 1 | Save return address |
| aa_o | output | 1 | Branch target is absolute |
| upd_o | output | 1 | Write effective address back to base |
| len_o | output | 4 | Access length in bytes |
| crf_o | output | 3 | Compare destination field |
| sh_o | output | 5 | Immediate rotate amount |
| mb_o | output | 5 | Mask begin |
| me_o | output | 5 | Mask end |

## Verification
The checks assume that the instruction word is fully driven: no X or Z bits ever reach the decoder. They also assume the word is stable when outputs are evaluated, because the block has no register to hide transient values. The bench initializes the word before time zero. It changes the word only on the falling clock edge and observes the outputs one nanosecond later, so every evaluation sees a settled, known word. Stimulus deliberately includes edge field values (0, 31, an all-ones displacement, a negative branch offset) and near-miss encodings (add with the overflow bit set, unused extended opcodes).

// File: rtl/power_subset_decoder.sv
module power_subset_decoder (
  input  logic [31:0] insn_i,
  output logic        illegal_o,
  output logic [3:0]  op_o,
  output logic        wr_en_o,
  output logic [4:0]  wr_sel_o,
  output logic        rd1_en_o,
  output logic [4:0]  rd1_sel_o,
  output logic        rd2_en_o,
  output logic [4:0]  rd2_sel_o,
  output logic        rd3_en_o,
  output logic [4:0]  rd3_sel_o,
  output logic [31:0] imm_o,
  output logic        rc_o,
  output logic        lk_o,
  output logic        aa_o,
  output logic        upd_o,
  output logic [3:0]  len_o,
  output logic [2:0]  crf_o,
  output logic [4:0]  sh_o,
  output logic [4:0]  mb_o,
  output logic [4:0]  me_o
);

  localparam logic [3:0] OP_NONE = 4'd0, OP_ADD = 4'd1, OP_AND = 4'd2,
                         OP_OR   = 4'd3, OP_LD  = 4'd4, OP_ST  = 4'd5,
                         OP_CMP  = 4'd6, OP_BR  = 4'd7, OP_ROT = 4'd8;

  logic [5:0] prim;
  logic [4:0] f_hi, f_mid, f_lo;
  logic [9:0] xop;
  logic [15:0] fld16;
  logic recbit;

  assign prim   = insn_i[31:26];
  assign f_hi   = insn_i[25:21];
  assign f_mid  = insn_i[20:16];
  assign f_lo   = insn_i[15:11];
  assign xop    = insn_i[10:1];
  assign fld16  = insn_i[15:0];
  assign recbit = insn_i[0];

  always_comb begin
    illegal_o = 1'b0;
    op_o      = OP_NONE;
    wr_en_o   = 1'b0;
    wr_sel_o  = 5'd0;
    rd1_en_o  = 1'b0;
    rd1_sel_o = 5'd0;
    rd2_en_o  = 1'b0;
    rd2_sel_o = 5'd0;
    rd3_en_o  = 1'b0;
    rd3_sel_o = 5'd0;
    imm_o     = 32'd0;
    rc_o      = 1'b0;
    lk_o      = 1'b0;
    aa_o      = 1'b0;
    upd_o     = 1'b0;
    len_o     = 4'd0;
    crf_o     = 3'd0;
    sh_o      = 5'd0;
    mb_o      = 5'd0;
    me_o      = 5'd0;

    unique case (prim)
      6'd14, 6'd15: begin
        op_o      = OP_ADD;
        wr_en_o   = 1'b1;
        wr_sel_o  = f_hi;
        rd1_en_o  = 1'b1;
        rd1_sel_o = f_mid;
        imm_o     = (prim == 6'd15) ? {fld16, 16'd0} : {16'd0, fld16};
      end
      6'd24, 6'd28: begin
        op_o      = (prim == 6'd24) ? OP_OR : OP_AND;
        wr_en_o   = 1'b1;
        wr_sel_o  = f_mid;
        rd3_en_o  = 1'b1;
        rd3_sel_o = f_hi;
        imm_o     = {16'd0, fld16};
        rc_o      = (prim == 6'd28);
      end
      6'd32, 6'd33, 6'd34, 6'd40: begin
        op_o      = OP_LD;
        wr_en_o   = 1'b1;
        wr_sel_o  = f_hi;
        rd1_en_o  = 1'b1;
        rd1_sel_o = f_mid;
        imm_o     = {16'd0, fld16};
        upd_o     = (prim == 6'd33);
        len_o     = (prim == 6'd34) ? 4'd1 : (prim == 6'd40) ? 4'd2 : 4'd4;
      end
      6'd36, 6'd37, 6'd38, 6'd44: begin
        op_o      = OP_ST;
        rd1_en_o  = 1'b1;
        rd1_sel_o = f_mid;
        rd3_en_o  = 1'b1;
        rd3_sel_o = f_hi;
        imm_o     = {16'd0, fld16};
        upd_o     = (prim == 6'd37);
        len_o     = (prim == 6'd38) ? 4'd1 : (prim == 6'd44) ? 4'd2 : 4'd4;
      end
      6'd18: begin
        op_o  = OP_BR;
        imm_o = {{6{insn_i[25]}}, insn_i[25:2], 2'b00};
        aa_o  = insn_i[1];
        lk_o  = insn_i[0];
      end
      6'd20, 6'd21, 6'd23: begin
        op_o      = OP_ROT;
        wr_en_o   = 1'b1;
        wr_sel_o  = f_mid;
        rd3_en_o  = 1'b1;
        rd3_sel_o = f_hi;
        mb_o      = insn_i[10:6];
        me_o      = insn_i[5:1];
        rc_o      = recbit;
        if (prim == 6'd23) begin
          rd2_en_o  = 1'b1;
          rd2_sel_o = f_lo;
        end else begin
          sh_o = f_lo;
        end
      end
      6'd31: begin
        unique case (xop)
          10'd266: begin
            op_o      = OP_ADD;
            wr_en_o   = 1'b1;
            wr_sel_o  = f_hi;
            rd1_en_o  = 1'b1;
            rd1_sel_o = f_mid;
            rd2_en_o  = 1'b1;
            rd2_sel_o = f_lo;
            rc_o      = recbit;
          end
          10'd28, 10'd444: begin
            op_o      = (xop == 10'd28) ? OP_AND : OP_OR;
            wr_en_o   = 1'b1;
            wr_sel_o  = f_mid;
            rd2_en_o  = 1'b1;
            rd2_sel_o = f_lo;
            rd3_en_o  = 1'b1;
            rd3_sel_o = f_hi;
            rc_o      = recbit;
          end
          10'd0: begin
            op_o      = OP_CMP;
            rd1_en_o  = 1'b1;
            rd1_sel_o = f_mid;
            rd2_en_o  = 1'b1;
            rd2_sel_o = f_lo;
            crf_o     = insn_i[25:23];
          end
          10'd23: begin
            op_o      = OP_LD;
            wr_en_o   = 1'b1;
            wr_sel_o  = f_hi;
            rd1_en_o  = 1'b1;
            rd1_sel_o = f_mid;
            rd2_en_o  = 1'b1;
            rd2_sel_o = f_lo;
            len_o     = 4'd4;
          end
          10'd151: begin
            op_o      = OP_ST;
            rd1_en_o  = 1'b1;
            rd1_sel_o = f_mid;
            rd2_en_o  = 1'b1;
            rd2_sel_o = f_lo;
            rd3_en_o  = 1'b1;
            rd3_sel_o = f_hi;
            len_o     = 4'd4;
          end
          default: illegal_o = 1'b1;
        endcase
      end
      default: illegal_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/power_subset_decoder_checker.sv
module power_subset_decoder_checker (
  input logic [31:0] insn_i,
  input logic        illegal_o,
  input logic [3:0]  op_o,
  input logic        wr_en_o,
  input logic [4:0]  wr_sel_o,
  input logic        rd1_en_o,
  input logic [4:0]  rd1_sel_o,
  input logic        rd2_en_o,
  input logic [4:0]  rd2_sel_o,
  input logic        rd3_en_o,
  input logic [4:0]  rd3_sel_o,
  input logic [31:0] imm_o,
  input logic        rc_o,
  input logic        lk_o,
  input logic        aa_o,
  input logic        upd_o,
  input logic [3:0]  len_o,
  input logic [2:0]  crf_o,
  input logic [4:0]  sh_o,
  input logic [4:0]  mb_o,
  input logic [4:0]  me_o
);
  logic is_mem;
  assign is_mem = (op_o == 4'd4) || (op_o == 4'd5);

  always_comb begin
    assert_illegal_quiet_R12: assert (!illegal_o ||
      (op_o == 4'd0 && !wr_en_o && !rd1_en_o && !rd2_en_o && !rd3_en_o && imm_o == 32'd0));
    assert_len_shape_R7: assert ($onehot0(len_o) && ((len_o != 4'd0) == is_mem));
    assert_update_memonly_R6: assert (!upd_o || is_mem);
    assert_store_nowrite_R3: assert (op_o != 4'd5 || (!wr_en_o && rd3_en_o && rd1_en_o));
    assert_branch_align_R9: assert (op_o != 4'd7 || (imm_o[1:0] == 2'b00 && !wr_en_o && !rd1_en_o));
    assert_link_branchonly_R9: assert (!(lk_o || aa_o) || op_o == 4'd7);
    assert_crf_cmponly_R10: assert (crf_o == 3'd0 || op_o == 4'd6);
    assert_idle_sel_R13: assert ((wr_en_o || wr_sel_o == 5'd0) && (rd1_en_o || rd1_sel_o == 5'd0) &&
                                 (rd2_en_o || rd2_sel_o == 5'd0) && (rd3_en_o || rd3_sel_o == 5'd0));
    assert_rotfields_R11: assert (op_o == 4'd8 || (sh_o == 5'd0 && mb_o == 5'd0 && me_o == 5'd0));
  end
endmodule

bind power_subset_decoder power_subset_decoder_checker u_chk (.*);

// File: tb/power_subset_decoder_bench.sv
`timescale 1ns/1ps
module power_subset_decoder_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] insn = 32'd0;
  logic        illegal, wr_en, rd1_en, rd2_en, rd3_en, rc, lk, aa, upd;
  logic [3:0]  op, len;
  logic [4:0]  wr_sel, rd1_sel, rd2_sel, rd3_sel, sh, mb, me;
  logic [31:0] imm;
  logic [2:0]  crf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  power_subset_decoder u_power_subset_decoder (
    .insn_i(insn), .illegal_o(illegal), .op_o(op),
    .wr_en_o(wr_en), .wr_sel_o(wr_sel), .rd1_en_o(rd1_en), .rd1_sel_o(rd1_sel),
    .rd2_en_o(rd2_en), .rd2_sel_o(rd2_sel), .rd3_en_o(rd3_en), .rd3_sel_o(rd3_sel),
    .imm_o(imm), .rc_o(rc), .lk_o(lk), .aa_o(aa), .upd_o(upd), .len_o(len),
    .crf_o(crf), .sh_o(sh), .mb_o(mb), .me_o(me));

  function automatic logic [31:0] dform(int po, int a, int b, logic [15:0] d);
    return {po[5:0], a[4:0], b[4:0], d};
  endfunction
  function automatic logic [31:0] xform(int a, int b, int c, int xo, bit r);
    return {6'd31, a[4:0], b[4:0], c[4:0], xo[9:0], r};
  endfunction
  function automatic logic [31:0] mform(int po, int s, int a, int c, int b0, int e0, bit r);
    return {po[5:0], s[4:0], a[4:0], c[4:0], b0[4:0], e0[4:0], r};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w);
    @(negedge clk);
    insn = w;
    #1;
  endtask

  task automatic t_reset;
    #1;
    chk("R12", "idle word illegal", {31'd0, illegal}, 32'd1);
    chk("R12", "idle op", {28'd0, op}, 32'd0);
  endtask

  task automatic t_regreg;
    apply(xform(3, 4, 5, 266, 1'b1));
    chk("R1", "add op", {28'd0, op}, 32'd1);
    chk("R2", "add wr", {26'd0, wr_en, wr_sel}, {26'd0, 1'b1, 5'd3});
    chk("R2", "add rd1", {26'd0, rd1_en, rd1_sel}, {26'd0, 1'b1, 5'd4});
    chk("R2", "add rd2", {26'd0, rd2_en, rd2_sel}, {26'd0, 1'b1, 5'd5});
    chk("R8", "add. rc", {31'd0, rc}, 32'd1);
    chk("R13", "add rd3 idle", {26'd0, rd3_en, rd3_sel}, 32'd0);
    apply(xform(8, 7, 9, 28, 1'b0));
    chk("R1", "and op", {28'd0, op}, 32'd2);
    chk("R4", "and wr", {27'd0, wr_sel}, 32'd7);
    chk("R4", "and rd3", {26'd0, rd3_en, rd3_sel}, {26'd0, 1'b1, 5'd8});
    chk("R4", "and rd2", {27'd0, rd2_sel}, 32'd9);
    chk("R8", "and rc", {31'd0, rc}, 32'd0);
    apply(xform(31, 0, 17, 444, 1'b1));
    chk("R1", "or op", {28'd0, op}, 32'd3);
    chk("R4", "or wr", {26'd0, wr_en, wr_sel}, {26'd0, 1'b1, 5'd0});
    chk("R4", "or rd3", {27'd0, rd3_sel}, 32'd31);
    chk("R8", "or. rc", {31'd0, rc}, 32'd1);
    apply(xform(12, 13, 14, 23, 1'b1));
    chk("R1", "lwzx op", {28'd0, op}, 32'd4);
    chk("R2", "lwzx ports", {17'd0, wr_sel, rd1_sel, rd2_sel}, {17'd0, 5'd12, 5'd13, 5'd14});
    chk("R7", "lwzx len", {28'd0, len}, 32'd4);
    chk("R8", "lwzx rc", {31'd0, rc}, 32'd0);
    apply(xform(20, 21, 22, 151, 1'b0));
    chk("R1", "stwx op", {28'd0, op}, 32'd5);
    chk("R3", "stwx ports", {14'd0, wr_en, rd3_sel, rd1_sel, rd2_sel}, {14'd0, 1'b0, 5'd20, 5'd21, 5'd22});
  endtask

  task automatic t_regimm;
    apply(dform(14, 6, 2, 16'h7FFF));
    chk("R1", "addi op", {28'd0, op}, 32'd1);
    chk("R2", "addi ports", {22'd0, wr_sel, rd1_sel}, {22'd0, 5'd6, 5'd2});
    chk("R5", "addi imm", imm, 32'h0000_7FFF);
    apply(dform(15, 1, 30, 16'h1234));
    chk("R5", "addis imm", imm, 32'h1234_0000);
    apply(dform(24, 5, 9, 16'hABCD));
    chk("R1", "ori op", {28'd0, op}, 32'd3);
    chk("R4", "ori ports", {21'd0, rd3_en, wr_sel, rd3_sel}, {21'd0, 1'b1, 5'd9, 5'd5});
    chk("R5", "ori imm", imm, 32'h0000_ABCD);
    chk("R13", "ori rd1 idle", {26'd0, rd1_en, rd1_sel}, 32'd0);
    chk("R8", "ori rc", {31'd0, rc}, 32'd0);
    apply(dform(28, 2, 3, 16'h00F0));
    chk("R1", "andi. op", {28'd0, op}, 32'd2);
    chk("R8", "andi. rc", {31'd0, rc}, 32'd1);
    chk("R4", "andi. wr", {27'd0, wr_sel}, 32'd3);
  endtask

  task automatic t_ldst;
    apply(dform(32, 4, 1, 16'd100));
    chk("R2", "lwz ports", {22'd0, wr_sel, rd1_sel}, {22'd0, 5'd4, 5'd1});
    chk("R5", "lwz imm", imm, 32'd100);
    chk("R6", "lwz upd", {31'd0, upd}, 32'd0);
    chk("R7", "lwz len", {28'd0, len}, 32'd4);
    apply(dform(33, 4, 1, 16'hFFFF));
    chk("R6", "lwzu upd", {31'd0, upd}, 32'd1);
    chk("R5", "lwzu imm", imm, 32'h0000_FFFF);
    apply(dform(34, 0, 31, 16'd2));
    chk("R7", "lbz len", {28'd0, len}, 32'd1);
    apply(dform(40, 0, 31, 16'd2));
    chk("R7", "lhz len", {28'd0, len}, 32'd2);
    apply(dform(36, 10, 11, 16'd8));
    chk("R1", "stw op", {28'd0, op}, 32'd5);
    chk("R3", "stw ports", {16'd0, wr_en, rd3_en, rd3_sel, rd1_sel}, {16'd0, 1'b0, 1'b1, 5'd10, 5'd11});
    chk("R6", "stw upd", {31'd0, upd}, 32'd0);
    apply(dform(37, 10, 11, 16'd8));
    chk("R6", "stwu upd", {31'd0, upd}, 32'd1);
    apply(dform(38, 10, 11, 16'd8));
    chk("R7", "stb len", {28'd0, len}, 32'd1);
    apply(dform(44, 10, 11, 16'd8));
    chk("R7", "sth len", {28'd0, len}, 32'd2);
    chk("R6", "sth upd", {31'd0, upd}, 32'd0);
  endtask

  task automatic t_cmp;
    apply(xform(5 << 2, 6, 7, 0, 1'b0));
    chk("R1", "cmp op", {28'd0, op}, 32'd6);
    chk("R10", "cmp crf", {29'd0, crf}, 32'd5);
    chk("R10", "cmp ports", {21'd0, wr_en, rd1_sel, rd2_sel}, {21'd0, 1'b0, 5'd6, 5'd7});
    chk("R7", "cmp len", {28'd0, len}, 32'd0);
    apply(xform(7 << 2, 0, 31, 0, 1'b0));
    chk("R10", "cmp crf 7", {29'd0, crf}, 32'd7);
  endtask

  task automatic t_rot;
    apply(mform(21, 3, 4, 10, 2, 29, 1'b1));
    chk("R1", "rlwinm op", {28'd0, op}, 32'd8);
    chk("R4", "rlwinm ports", {22'd0, wr_sel, rd3_sel}, {22'd0, 5'd4, 5'd3});
    chk("R11", "rlwinm fields", {17'd0, sh, mb, me}, {17'd0, 5'd10, 5'd2, 5'd29});
    chk("R8", "rlwinm. rc", {31'd0, rc}, 32'd1);
    chk("R13", "rlwinm rd2 idle", {26'd0, rd2_en, rd2_sel}, 32'd0);
    apply(mform(23, 5, 6, 7, 0, 31, 1'b0));
    chk("R11", "rlwnm rd2", {26'd0, rd2_en, rd2_sel}, {26'd0, 1'b1, 5'd7});
    chk("R11", "rlwnm fields", {17'd0, sh, mb, me}, {17'd0, 5'd0, 5'd0, 5'd31});
    chk("R8", "rlwnm rc", {31'd0, rc}, 32'd0);
    apply(mform(20, 1, 2, 31, 16, 15, 1'b0));
    chk("R11", "rlwimi fields", {17'd0, sh, mb, me}, {17'd0, 5'd31, 5'd16, 5'd15});
  endtask

  task automatic t_branch;
    apply({6'd18, 24'h000123, 1'b0, 1'b0});
    chk("R1", "b op", {28'd0, op}, 32'd7);
    chk("R9", "b imm", imm, 32'h0000_048C);
    chk("R9", "b flags", {30'd0, aa, lk}, 32'd0);
    chk("R13", "b ports idle", {28'd0, wr_en, rd1_en, rd2_en, rd3_en}, 32'd0);
    apply({6'd18, 24'h800000, 1'b1, 1'b1});
    chk("R9", "bla imm", imm, 32'hFE00_0000);
    chk("R9", "bla flags", {30'd0, aa, lk}, 32'd3);
    chk("R8", "bla rc", {31'd0, rc}, 32'd0);
    apply(dform(32, 0, 0, 16'h0003));
    chk("R9", "load flags", {30'd0, aa, lk}, 32'd0);
  endtask

  task automatic t_illegal;
    apply(32'hFFFF_FFFF);
    chk("R12", "op 63", {27'd0, illegal, op}, {27'd0, 1'b1, 4'd0});
    chk("R12", "op 63 quiet", {14'd0, wr_en, rd1_en, rd2_en, rd3_en, rc, lk, aa, upd, len, crf, 3'd0}, 32'd0);
    chk("R12", "op 63 imm", imm, 32'd0);
    apply(xform(1, 2, 3, 999, 1'b1));
    chk("R12", "xo 999", {27'd0, illegal, op}, {27'd0, 1'b1, 4'd0});
    apply(xform(1, 2, 3, 778, 1'b0));
    chk("R12", "add oe", {31'd0, illegal}, 32'd1);
    chk("R12", "add oe ports", {28'd0, wr_en, rd1_en, rd2_en, rd3_en}, 32'd0);
    apply(dform(16, 1, 2, 16'h1234));
    chk("R12", "op 16", {27'd0, illegal, op}, {27'd0, 1'b1, 4'd0});
  endtask

  initial begin
    t_reset();
    t_regreg();
    t_regimm();
    t_ldst();
    t_cmp();
    t_rot();
    t_branch();
    t_illegal();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule